// File: doc/BRIEF.md
# Associative Memory Road Finder

This block finds candidate track roads in streamed detector hits. It holds a bank of track patterns. Each pattern stores one coarse hit address for every detector layer. Hits arrive one per cycle, each tagged with its layer. Every pattern compares the hit against its own stored address for that layer, all patterns in the same cycle. On a match the pattern sets a sticky bit for that layer.

When the event closes, each pattern counts its matched layers and compares the count with a majority threshold. Patterns that reach the threshold become roads. The roads are streamed out one per cycle, lowest pattern index first, over a valid/ready channel, with a flag on the final road. After the readout drains, the match bits are wiped and the next event starts from zero.

Patterns are written through a simple write port that takes a pattern index, a layer and an address. The port only accepts writes while no event is in progress.

Top module: `am_road_finder`

## Requirements
- R1: After reset, `road_valid` and `busy` are 0.
- R2: A pattern write (`load_en`) takes effect only while `busy` is 0. A write presented while `busy` is 1 leaves the stored pattern unchanged. Write indices at or beyond the parameter limits are ignored.
- R3: A hit on layer L with address A sets layer bit L in every pattern whose stored address for layer L equals A. All patterns are updated in the same cycle. Hits whose layer is LAYERS or more match nothing.
- R4: A pattern fires when the number of distinct layers it has matched is greater than or equal to the threshold. Repeated hits on one layer count once.
- R5: The threshold is sampled in the cycle that `eoe` is accepted. A sampled value of 0 acts as 1. A value greater than LAYERS fires no pattern.
- R6: Fired roads are presented in strictly ascending pattern index. A new road is presented in each cycle in which the current one is taken. `road_last` is 1 only on the final road of the event.
- R7: While `road_valid` is 1 and `road_ready` is 0, `road_valid`, `road_id` and `road_last` hold their values.
- R8: `busy` rises in the cycle after the first hit or after `eoe`. For `eoe` sampled at clock edge E, `road_valid` is 0 after edge E+1. If any pattern fired, the first road is valid after edge E+2. `road_valid` is only ever 1 while `busy` is 1.
- R9: Once the last road is taken (or at once when no pattern fired), `busy` returns to 0 and all match bits are cleared. Matches never carry over into the next event.
- R10: Hits that arrive between the `eoe` cycle and the return of `busy` to 0 are ignored. They set no match bit in any event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Pattern write strobe |
| load_pat | input | PAT_W | Pattern index to write |
| load_layer | input | LYR_W | Layer to write |
| load_addr | input | ADDR_W | Address stored for that pattern and layer |
| threshold | input | CNT_W | Majority threshold, sampled with `eoe` |
| hit_valid | input | 1 | Hit strobe |
| hit_layer | input | LYR_W | Layer of the hit |
| hit_addr | input | ADDR_W | Coarse address of the hit |
| eoe | input | 1 | End of event |
| road_ready | input | 1 | Consumer accepts the road |
| road_valid | output | 1 | A road is presented |
| road_id | output | PAT_W | Index of the fired pattern |
| road_last | output | 1 | Final road of the event |
| busy | output | 1 | An event or its readout is in progress |

## Verification
The assertions check the output handshake on every cycle. They cover the post-reset state, the hold of the road while it is stalled, the strictly rising road index, the drop of `road_valid` after the last road, and that roads appear only while busy. Whether the correct patterns fire needs the bench's scenarios. Those scenarios cover the layer-count majority with duplicate hits, the clamping of the threshold, writes and hits that must be ignored, and the clearing of matches between events. The bench's scoreboard predicts each event's road list from its own copy of the pattern bank.

// File: rtl/am_pkg.sv
package am_pkg;

  // Control phases of one event
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // no event, pattern writes allowed
    ST_ACTIVE = 2'd1,  // hits being collected
    ST_EVAL   = 2'd2,  // majority decision being registered
    ST_READ   = 2'd3   // roads streaming out
  } am_state_t;

  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/am_ctrl.sv
module am_ctrl
  import am_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_valid,
  input  logic eoe,
  input  logic drained,
  output logic busy,
  output logic load_ok,
  output logic hit_ok,
  output logic eval,
  output logic clr
);

  am_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (eoe)            state_q <= ST_EVAL;
          else if (hit_valid) state_q <= ST_ACTIVE;
        end
        ST_ACTIVE: begin
          if (eoe) state_q <= ST_EVAL;
        end
        ST_EVAL: state_q <= ST_READ;
        ST_READ: begin
          if (drained) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy    = (state_q != ST_IDLE);
    load_ok = (state_q == ST_IDLE);
    hit_ok  = (state_q == ST_IDLE) || (state_q == ST_ACTIVE);
    eval    = (state_q == ST_EVAL);
    clr     = (state_q == ST_READ) && drained;
  end

endmodule

// File: rtl/am_pattern_cell.sv
module am_pattern_cell #(
  parameter int LAYERS = 6,
  parameter int ADDR_W = 8,
  parameter int LYR_W  = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LYR_W-1:0]  wr_layer,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              hit_en,
  input  logic [LYR_W-1:0]  hit_layer,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              clr,
  input  logic [CNT_W-1:0]  thr,
  output logic              fire
);

  // Stored address per layer (contents are not reset)
  logic [ADDR_W-1:0] addr_q [LAYERS];
  logic [LAYERS-1:0] match_q;
  logic [LAYERS-1:0] cmp;
  logic [CNT_W-1:0]  layer_cnt;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LAYERS; l++) begin
      if (wr_en && (wr_layer == LYR_W'(l))) addr_q[l] <= wr_addr;
    end
  end

  // Content compare: one comparator per layer
  always_comb begin
    for (int l = 0; l < LAYERS; l++) begin
      cmp[l] = hit_en && (hit_layer == LYR_W'(l)) && (addr_q[l] == hit_addr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) match_q <= '0;
    else            match_q <= match_q | cmp;
  end

  // Majority: count matched layers
  always_comb begin
    layer_cnt = '0;
    for (int l = 0; l < LAYERS; l++) begin
      layer_cnt = layer_cnt + CNT_W'(match_q[l]);
    end
    fire = (layer_cnt >= thr);
  end

endmodule

// File: rtl/am_road_encoder.sv
module am_road_encoder #(
  parameter int PATTERNS = 32,
  parameter int PAT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [PATTERNS-1:0] fire_vec,
  input  logic                ready,
  output logic                valid,
  output logic [PAT_W-1:0]    id,
  output logic                last,
  output logic                drained
);

  logic [PATTERNS-1:0] pend_q;
  logic [PATTERNS-1:0] rest;
  logic [PAT_W-1:0]    sel;
  logic                advance;

  // Lowest set index wins
  always_comb begin
    sel = '0;
    for (int i = PATTERNS - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = PAT_W'(i);
    end
    rest    = pend_q & ~(PATTERNS'(1) << sel);
    advance = !valid || ready;
    drained = (pend_q == '0) && advance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      valid  <= 1'b0;
      id     <= '0;
      last   <= 1'b0;
    end else if (capture) begin
      pend_q <= fire_vec;
    end else if (advance) begin
      if (pend_q != '0) begin
        valid  <= 1'b1;
        id     <= sel;
        last   <= (rest == '0);
        pend_q <= rest;
      end else begin
        valid <= 1'b0;
        last  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/am_road_finder.sv
module am_road_finder #(
  parameter int LAYERS   = 6,
  parameter int ADDR_W   = 8,
  parameter int PATTERNS = 32,
  localparam int PAT_W   = am_pkg::width_of(PATTERNS),
  localparam int LYR_W   = am_pkg::width_of(LAYERS),
  localparam int CNT_W   = $clog2(LAYERS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [PAT_W-1:0]  load_pat,
  input  logic [LYR_W-1:0]  load_layer,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              hit_valid,
  input  logic [LYR_W-1:0]  hit_layer,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              eoe,
  input  logic              road_ready,
  output logic              road_valid,
  output logic [PAT_W-1:0]  road_id,
  output logic              road_last,
  output logic              busy
);

  logic                load_ok, hit_ok, eval, clr, drained;
  logic                hit_en;
  logic [CNT_W-1:0]    thr_q;
  logic [PATTERNS-1:0] fire_vec;

  am_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .hit_valid (hit_valid),
    .eoe       (eoe),
    .drained   (drained),
    .busy      (busy),
    .load_ok   (load_ok),
    .hit_ok    (hit_ok),
    .eval      (eval),
    .clr       (clr)
  );

  assign hit_en = hit_valid && hit_ok;

  // Threshold sampled when the event closes; zero behaves as one
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= CNT_W'(1);
    end else if (eoe && hit_ok) begin
      thr_q <= (threshold == '0) ? CNT_W'(1) : threshold;
    end
  end

  for (genvar p = 0; p < PATTERNS; p++) begin : g_cell
    logic wr_sel;
    assign wr_sel = load_en && load_ok && (load_pat == PAT_W'(p));

    am_pattern_cell #(
      .LAYERS (LAYERS),
      .ADDR_W (ADDR_W),
      .LYR_W  (LYR_W),
      .CNT_W  (CNT_W)
    ) u_cell (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_sel),
      .wr_layer  (load_layer),
      .wr_addr   (load_addr),
      .hit_en    (hit_en),
      .hit_layer (hit_layer),
      .hit_addr  (hit_addr),
      .clr       (clr),
      .thr       (thr_q),
      .fire      (fire_vec[p])
    );
  end

  am_road_encoder #(
    .PATTERNS (PATTERNS),
    .PAT_W    (PAT_W)
  ) u_enc (
    .clk      (clk),
    .rst      (rst),
    .capture  (eval),
    .fire_vec (fire_vec),
    .ready    (road_ready),
    .valid    (road_valid),
    .id       (road_id),
    .last     (road_last),
    .drained  (drained)
  );

endmodule

// File: rtl/am_road_finder_chk.sv
module am_road_finder_chk #(
  parameter int PATTERNS = 32,
  localparam int PAT_W   = am_pkg::width_of(PATTERNS)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             road_valid,
  input logic             road_ready,
  input logic [PAT_W-1:0] road_id,
  input logic             road_last
);

  // R1: idle outputs right after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!road_valid && !busy));

  // R7: stalled road holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (road_valid && !road_ready) |=>
      (road_valid && $stable(road_id) && $stable(road_last)));

  // R6: next road has a higher index, presented at once
  p_order_r6: assert property (@(posedge clk) disable iff (rst)
    (road_valid && road_ready && !road_last) |=>
      (road_valid && (road_id > $past(road_id))));

  // R6: nothing after the final road
  p_last_end_r6: assert property (@(posedge clk) disable iff (rst)
    (road_valid && road_ready && road_last) |=> !road_valid);

  // R8: roads only during an event
  p_road_busy_r8: assert property (@(posedge clk) disable iff (rst)
    road_valid |-> busy);

endmodule

bind am_road_finder am_road_finder_chk #(.PATTERNS(PATTERNS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .road_valid (road_valid),
  .road_ready (road_ready),
  .road_id    (road_id),
  .road_last  (road_last)
);

// File: tb/am_road_finder_test.sv
module am_road_finder_test;

  localparam int LAYERS   = 6;
  localparam int ADDR_W   = 8;
  localparam int PATTERNS = 32;
  localparam int PAT_W    = 5;
  localparam int LYR_W    = 3;
  localparam int CNT_W    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load_en = 1'b0;
  logic [PAT_W-1:0]  load_pat = '0;
  logic [LYR_W-1:0]  load_layer = '0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [CNT_W-1:0]  threshold = '0;
  logic              hit_valid = 1'b0;
  logic [LYR_W-1:0]  hit_layer = '0;
  logic [ADDR_W-1:0] hit_addr = '0;
  logic              eoe = 1'b0;
  logic              road_ready = 1'b1;
  logic              road_valid;
  logic [PAT_W-1:0]  road_id;
  logic              road_last;
  logic              busy;

  am_road_finder #(.LAYERS(LAYERS), .ADDR_W(ADDR_W), .PATTERNS(PATTERNS)) uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_pat(load_pat),
    .load_layer(load_layer), .load_addr(load_addr), .threshold(threshold),
    .hit_valid(hit_valid), .hit_layer(hit_layer), .hit_addr(hit_addr),
    .eoe(eoe), .road_ready(road_ready), .road_valid(road_valid),
    .road_id(road_id), .road_last(road_last), .busy(busy)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int bp_mode = 0;
  bit done    = 1'b0;
  int exp_q[$];

  // Bench model of the pattern bank
  int m_pat [PATTERNS][LAYERS];
  bit m_match [PATTERNS][LAYERS];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat_addr(input int p, input int l);
    int a;
    a = ((p >> 1) * 11 + l * 37 + 5) & 255;
    if ((p % 2 == 1) && (l == LAYERS - 1)) a = a ^ 8'h80;
    return a;
  endfunction

  // Backpressure driver
  always @(posedge clk) begin
    cyc++;
    #1;
    case (bp_mode)
      1:       road_ready = (cyc % 2 == 0);
      2:       road_ready = (cyc % 4 == 0);
      default: road_ready = 1'b1;
    endcase
  end

  // Scoreboard monitor
  bit       stalled = 1'b0;
  int       stall_id = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (stalled) begin
        check(road_valid && (int'(road_id) == stall_id), "R7 hold", int'(road_id), stall_id);
      end
      stalled = road_valid && !road_ready;
      stall_id = int'(road_id);
      if (road_valid && road_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected road", int'(road_id), -1);
        end else begin
          check(int'(road_id) == exp_q[0], "R6 road id", int'(road_id), exp_q[0]);
          check(road_last == (exp_q.size() == 1), "R6 last flag", int'(road_last), int'(exp_q.size() == 1));
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic load(input int p, input int l, input int a, input bit apply);
    load_en = 1'b1; load_pat = PAT_W'(p); load_layer = LYR_W'(l); load_addr = ADDR_W'(a);
    if (apply) m_pat[p][l] = a;
    @(posedge clk); #1;
    load_en = 1'b0;
  endtask

  task automatic hit(input int l, input int a, input bit apply);
    hit_valid = 1'b1; hit_layer = LYR_W'(l); hit_addr = ADDR_W'(a);
    if (apply && l < LAYERS) begin
      for (int p = 0; p < PATTERNS; p++) if (m_pat[p][l] == a) m_match[p][l] = 1'b1;
    end
    @(posedge clk); #1;
    hit_valid = 1'b0;
  endtask

  task automatic end_event(input int thr, input bit ir_en, input int ir_l, input int ir_a);
    int eff;
    int nexp;
    eff = (thr == 0) ? 1 : thr;
    nexp = 0;
    for (int p = 0; p < PATTERNS; p++) begin
      int c;
      c = 0;
      for (int l = 0; l < LAYERS; l++) c += int'(m_match[p][l]);
      if (c >= eff) begin exp_q.push_back(p); nexp++; end
    end
    eoe = 1'b1; threshold = CNT_W'(thr);
    @(posedge clk); #1;
    eoe = 1'b0;
    check(busy == 1'b1, "R8 busy after eoe", int'(busy), 1);
    check(road_valid == 1'b0, "R8 no road in eval", int'(road_valid), 0);
    @(posedge clk); #1;
    check(road_valid == 1'b0, "R8 no road after E+1", int'(road_valid), 0);
    @(posedge clk); #1;
    check(road_valid == (nexp > 0), "R8 first road at E+2", int'(road_valid), int'(nexp > 0));
    if (ir_en) begin
      check(busy == 1'b1, "R10 busy during readout", int'(busy), 1);
      hit(ir_l, ir_a, 1'b0);
    end
    while (busy) begin @(posedge clk); #1; end
    check(exp_q.size() == 0, "R9 all roads drained", exp_q.size(), 0);
    check(road_valid == 1'b0, "R9 idle no road", int'(road_valid), 0);
    for (int p = 0; p < PATTERNS; p++)
      for (int l = 0; l < LAYERS; l++) m_match[p][l] = 1'b0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < PATTERNS; p++)
      for (int l = 0; l < LAYERS; l++) m_match[p][l] = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check(road_valid == 1'b0, "R1 reset valid", int'(road_valid), 0);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);

    // R2: fill the bank; out-of-range layer write ignored
    for (int p = 0; p < PATTERNS; p++)
      for (int l = 0; l < LAYERS; l++) load(p, l, pat_addr(p, l), 1'b1);
    load(4, 7, 8'hFF, 1'b0);

    // R3/R4: full six-layer match, threshold 6 -> only pattern 4
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(4, l), 1'b1);
    check(busy == 1'b1, "R8 busy after hit", int'(busy), 1);
    end_event(6, 1'b0, 0, 0);
    // R4: threshold 5 -> patterns 4 and 5 in parallel
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(4, l), 1'b1);
    hit(7, 0, 1'b1);  // R3 out-of-range layer
    end_event(5, 1'b0, 0, 0);

    // R6: several roads under alternating backpressure
    bp_mode = 1;
    for (int l = 0; l < 3; l++) hit(l, pat_addr(20, l), 1'b1);
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(10, l), 1'b1);
    for (int l = 0; l < 4; l++) hit(l, pat_addr(3, l), 1'b1);
    end_event(3, 1'b0, 0, 0);

    // R4: repeated hits on one layer count once
    bp_mode = 0;
    hit(0, pat_addr(6, 0), 1'b1);
    hit(0, pat_addr(6, 0), 1'b1);
    hit(0, pat_addr(6, 0), 1'b1);
    hit(1, pat_addr(6, 1), 1'b1);
    end_event(3, 1'b0, 0, 0);

    // R5: zero threshold acts as one
    hit(2, pat_addr(12, 2), 1'b1);
    end_event(0, 1'b0, 0, 0);
    // R5: threshold above layer count fires nothing
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(14, l), 1'b1);
    end_event(7, 1'b0, 0, 0);

    // R10: hit during readout is ignored
    bp_mode = 2;
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(20, l), 1'b1);
    end_event(5, 1'b1, 0, pat_addr(22, 0));
    bp_mode = 0;
    for (int l = 1; l < LAYERS; l++) hit(l, pat_addr(22, l), 1'b1);
    end_event(6, 1'b0, 0, 0);

    // R2: write while busy ignored
    hit(0, pat_addr(0, 0), 1'b1);
    check(busy == 1'b1, "R2 busy before write", int'(busy), 1);
    load(0, 1, 8'h3C, 1'b0);
    end_event(6, 1'b0, 0, 0);
    for (int l = 0; l < LAYERS; l++) hit(l, pat_addr(0, l), 1'b1);
    end_event(6, 1'b0, 0, 0);

    // R9: matches do not carry over
    for (int l = 0; l < 3; l++) hit(l, pat_addr(30, l), 1'b1);
    end_event(6, 1'b0, 0, 0);
    for (int l = 3; l < LAYERS; l++) hit(l, pat_addr(30, l), 1'b1);
    end_event(6, 1'b0, 0, 0);

    // Empty event straight from idle
    end_event(1, 1'b0, 0, 0);

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule